// File: doc/BRIEF.md
# Fully Associative Translation Buffer With Process-Switch Flush

This block keeps a small set of recently used page translations close to the core. Each request carries a virtual page number and a read/write flag. The stored tags of every slot are compared against that number at the same time. The answer is registered: it comes back one clock later as a hit or a miss and, on a hit, the physical page number. When the request is a write and it hits, the slot is marked as modified.

After a miss, the page table walker (outside this block) installs the missing translation through the fill port. A fill goes to a slot as follows:
- If the page is already resident, the fill updates that slot in place.
- Otherwise, the fill takes the lowest-numbered empty slot.
- When no slot is empty, a slot picked by a free-running pseudo-random sequence is overwritten.
If an overwritten slot was marked modified, its page numbers are presented for one cycle on a write-back strobe, so that the page table can record the modification.

A flush input empties the whole buffer on a process switch. This keeps one process from using another process's translations.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every slot is empty and `rsp_valid` and `wb_valid` are 0; a lookup made before any fill returns a miss.
- R2: A lookup presented in cycle n yields `rsp_valid`=1 in cycle n+1, with `rsp_hit` and `rsp_ppn`. `rsp_ppn` is 0 on a miss. In a cycle with no lookup, `rsp_valid` is 0 in the next cycle.
- R3: After a fill of (vpn, ppn), a later lookup of vpn hits and returns that ppn.
- R4: A write lookup that hits marks the slot modified. Evicting that slot later raises `wb_valid`.
- R5: Read hits and fills with `fill_dirty`=0 leave a slot unmodified. Evicting such a slot leaves `wb_valid` at 0.
- R6: While any slot is empty, a fill evicts nothing: every earlier translation still hits and `wb_valid` stays 0.
- R7: When every slot holds a translation, a fill of a new page replaces exactly one resident page. If that page was modified, `wb_valid` is 1 for the cycle after the fill, with `wb_vpn` and `wb_ppn` holding the replaced translation.
- R8: A cycle with `flush`=1 empties every slot. Later lookups miss, and the flush raises no write-back.
- R9: A fill in the same cycle as a flush is dropped: its page misses afterwards.
- R10: A fill of a page that is already resident rewrites that slot's ppn in place. Other slots are left as they were, and no write-back is raised.
- R11: At most one slot matches any looked-up page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty every slot (process switch) |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store access |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Registered lookup result present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_dirty | input | 1 | Installed page is already modified |
| wb_valid | output | 1 | One-cycle strobe: a modified translation was replaced |
| wb_vpn | output | VPN_W | Virtual page number of the replaced translation |
| wb_ppn | output | PPN_W | Physical page number of the replaced translation |

## Verification
Both kinds of result are registered once. A lookup answer appears one cycle after the request, and a write-back strobe appears one cycle after the fill that caused it. Flush and dirty-bit updates take effect at the same edge, so they are seen on the next lookup.

The bench drives each stimulus after a falling edge and lets one rising edge pass. It then reads the outputs at the following falling edge, which is exactly the cycle in which they are due.

Victim choice is pseudo-random, so eviction is checked without predicting the victim. After the eviction the bench re-reads every earlier page and requires exactly one miss. It also requires that the strobe names that same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // where an accepted fill lands
  typedef enum logic [1:0] {
    PLACE_UPDATE = 2'd0,   // page already resident: rewrite its slot
    PLACE_FREE   = 2'd1,   // lowest empty slot
    PLACE_EVICT  = 2'd2    // pseudo-random resident slot
  } place_e;

  // maximal-length step, taps 16,15,13,4
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush_i,
  input  logic [VPN_W-1:0]                lk_vpn_i,
  input  logic                            wr_hit_en_i,
  input  logic [ENTRIES-1:0]              fill_sel_i,
  input  logic [VPN_W-1:0]                fill_vpn_i,
  input  logic [PPN_W-1:0]                fill_ppn_i,
  input  logic                            fill_dirty_i,
  input  logic                            fill_merge_i,
  output logic [ENTRIES-1:0]              lk_match_o,
  output logic [ENTRIES-1:0]              fill_match_o,
  output logic [ENTRIES-1:0]              valid_o,
  output logic [ENTRIES-1:0]              dirty_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]   tag_o,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_o
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q, d_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;
    logic             wr_here;

    assign lk_match_o[i]   = v_q && (tag_q == lk_vpn_i);
    assign fill_match_o[i] = v_q && (tag_q == fill_vpn_i);
    assign wr_here         = wr_hit_en_i && lk_match_o[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        d_q   <= 1'b0;
        tag_q <= '0;
        ppn_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_sel_i[i]) begin
        v_q   <= 1'b1;
        tag_q <= fill_vpn_i;
        ppn_q <= fill_ppn_i;
        d_q   <= fill_dirty_i | (fill_merge_i & (d_q | wr_here));
      end else if (wr_here) begin
        d_q <= 1'b1;
      end
    end

    assign valid_o[i] = v_q;
    assign dirty_o[i] = d_q;
    assign tag_o[i]   = tag_q;
    assign ppn_o[i]   = ppn_q;

    // R4: a write hit leaves the slot modified at the next edge
    assert_wr_hit_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_here && !flush_i && !fill_sel_i[i]) |=> d_q);
  end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  output logic               have_free_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic [IDX_W-1:0]   rand_idx_o
);

  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_step(lfsr_q);
  end

  assign rand_idx_o = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));

  // lowest-numbered empty slot
  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign have_free_o = ~&valid_i;

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  output logic             wb_valid,
  output logic [VPN_W-1:0] wb_vpn,
  output logic [PPN_W-1:0] wb_ppn
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [IDX_W-1:0] onehot_index(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  logic [ENTRIES-1:0]            lk_match, fill_match, valid_vec, dirty_vec, fill_sel;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PPN_W-1:0] ppns;
  logic                          have_free;
  logic [IDX_W-1:0]              free_idx, rand_idx, tgt_idx;
  place_e                        place;

  // named internal events
  logic ev_lookup_hit, ev_wr_hit, ev_fill, ev_evict, ev_wb;
  logic [PPN_W-1:0] hit_ppn;

  assign ev_lookup_hit = lk_valid && (|lk_match);
  assign ev_wr_hit     = ev_lookup_hit && lk_write;
  assign ev_fill       = fill_valid && !flush;

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) hit_ppn = hit_ppn | ppns[i];
    end
  end

  always_comb begin
    if (|fill_match)   place = PLACE_UPDATE;
    else if (have_free) place = PLACE_FREE;
    else                place = PLACE_EVICT;
  end

  always_comb begin
    case (place)
      PLACE_UPDATE: tgt_idx = onehot_index(fill_match);
      PLACE_FREE:   tgt_idx = free_idx;
      default:      tgt_idx = rand_idx;
    endcase
  end

  assign fill_sel = ev_fill ? (ENTRIES'(1) << tgt_idx) : '0;
  assign ev_evict = ev_fill && (place == PLACE_EVICT);
  assign ev_wb    = ev_evict &&
                    (dirty_vec[tgt_idx] || (ev_wr_hit && lk_match[tgt_idx]));

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .lk_vpn_i     (lk_vpn),
    .wr_hit_en_i  (lk_valid && lk_write),
    .fill_sel_i   (fill_sel),
    .fill_vpn_i   (fill_vpn),
    .fill_ppn_i   (fill_ppn),
    .fill_dirty_i (fill_dirty),
    .fill_merge_i (place == PLACE_UPDATE),
    .lk_match_o   (lk_match),
    .fill_match_o (fill_match),
    .valid_o      (valid_vec),
    .dirty_o      (dirty_vec),
    .tag_o        (tags),
    .ppn_o        (ppns)
  );

  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_vec),
    .have_free_o (have_free),
    .free_idx_o  (free_idx),
    .rand_idx_o  (rand_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      wb_valid  <= 1'b0;
      wb_vpn    <= '0;
      wb_ppn    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= ev_lookup_hit;
      rsp_ppn   <= ev_lookup_hit ? hit_ppn : '0;
      wb_valid  <= ev_wb;
      wb_vpn    <= ev_wb ? tags[tgt_idx] : '0;
      wb_ppn    <= ev_wb ? ppns[tgt_idx] : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_hit_needs_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0) && !wb_valid);
  assert_flush_beats_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_valid) |=> !wb_valid);
  assert_no_evict_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_vec) |=> !wb_valid);
  assert_wb_after_full_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(fill_valid && !flush && (&valid_vec)));
  assert_update_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill && (|fill_match)) |=> $countones(valid_vec) == $past($countones(valid_vec)));

endmodule

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;

  localparam int N     = 64;
  localparam int VPN_W = 19;
  localparam int PPN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic             lk_valid = 1'b0, lk_write = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic             rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  logic             fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             wb_valid;
  logic [VPN_W-1:0] wb_vpn;
  logic [PPN_W-1:0] wb_ppn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlb_assoc #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb_assoc (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_dirty(fill_dirty),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_ppn(wb_ppn)
  );

  // vector: [35:34] op, [33] write, [32:14] vpn, [13:2] ppn, [1] expected hit
  localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_FLUSH = 2'd2, OP_FLFILL = 2'd3;
  localparam int NV = 11;
  localparam logic [35:0] VEC [NV] = '{
    {OP_FILL,   1'b0, 19'h00010, 12'h123, 1'b0, 1'b0},
    {OP_LOOK,   1'b0, 19'h00010, 12'h123, 1'b1, 1'b0},  // R3
    {OP_LOOK,   1'b0, 19'h00011, 12'h000, 1'b0, 1'b0},  // R2 miss
    {OP_FILL,   1'b0, 19'h00011, 12'h456, 1'b0, 1'b0},
    {OP_LOOK,   1'b1, 19'h00011, 12'h456, 1'b1, 1'b0},  // R4 write hit
    {OP_FILL,   1'b0, 19'h00010, 12'h777, 1'b0, 1'b0},  // R10 refill
    {OP_LOOK,   1'b0, 19'h00010, 12'h777, 1'b1, 1'b0},  // R10, R11
    {OP_LOOK,   1'b0, 19'h00011, 12'h456, 1'b1, 1'b0},  // R10 others kept
    {OP_FLFILL, 1'b0, 19'h00020, 12'h001, 1'b0, 1'b0},  // R9
    {OP_LOOK,   1'b0, 19'h00020, 12'h000, 1'b0, 1'b0},  // R9 dropped
    {OP_LOOK,   1'b0, 19'h00010, 12'h000, 1'b0, 1'b0}   // R8 flushed
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input bit wr);
    lk_valid = 1'b1; lk_write = wr; lk_vpn = v;
    tick();
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input bit d, input bit fl);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_dirty = d; flush = fl;
    tick();
    fill_valid = 1'b0; fill_dirty = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
  endtask

  // fill N pages 0x100+i -> ppn i, then optionally write-hit each; fill one more
  task automatic full_case(input bit mark, input logic [VPN_W-1:0] newv, input logic [PPN_W-1:0] newp);
    int misses;
    logic [VPN_W-1:0] lost;
    logic got_wb;
    logic [VPN_W-1:0] got_vpn;
    logic [PPN_W-1:0] got_ppn;
    do_flush();
    for (int i = 0; i < N; i++) begin
      fill(VPN_W'(32'h100 + i), PPN_W'(i), 1'b0, 1'b0);
      chk(wb_valid == 1'b0, "R6 no write-back while free", 32'(wb_valid), 0);
    end
    for (int i = 0; i < N; i++) begin
      lookup(VPN_W'(32'h100 + i), mark);
      chk(rsp_hit && rsp_ppn == PPN_W'(i), "R6 earlier fill still hits", 32'(rsp_ppn), 32'(i));
    end
    fill(newv, newp, 1'b0, 1'b0);
    got_wb = wb_valid; got_vpn = wb_vpn; got_ppn = wb_ppn;
    if (mark) chk(got_wb == 1'b1, "R4 modified victim raises wb_valid", 32'(got_wb), 1);
    else      chk(got_wb == 1'b0, "R5 clean victim gives no write-back", 32'(got_wb), 0);
    misses = 0; lost = '0;
    for (int i = 0; i < N; i++) begin
      lookup(VPN_W'(32'h100 + i), 1'b0);
      if (!rsp_hit) begin misses++; lost = VPN_W'(32'h100 + i); end
    end
    chk(misses == 1, "R7 exactly one page replaced", 32'(misses), 1);
    lookup(newv, 1'b0);
    chk(rsp_hit && rsp_ppn == newp, "R7 new page hits", 32'(rsp_ppn), 32'(newp));
    if (mark) begin
      chk(got_vpn == lost, "R7 wb_vpn names replaced page", 32'(got_vpn), 32'(lost));
      chk(got_ppn == PPN_W'(lost - VPN_W'(32'h100)), "R7 wb_ppn of replaced page",
          32'(got_ppn), 32'(lost - VPN_W'(32'h100)));
    end
    tick();
    chk(wb_valid == 1'b0, "R7 strobe lasts one cycle", 32'(wb_valid), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(wb_valid == 1'b0, "R1 wb_valid after reset", 32'(wb_valid), 0);
    lookup(19'h5, 1'b0);
    chk(rsp_valid && !rsp_hit && rsp_ppn == '0, "R1 R2 cold lookup misses",
        {rsp_valid, rsp_hit, 18'd0, rsp_ppn}, 32'h80000000);
    tick();
    chk(rsp_valid == 1'b0, "R2 idle cycle drops rsp_valid", 32'(rsp_valid), 0);

    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      case (v[35:34])
        OP_LOOK: begin
          lookup(v[32:14], v[33]);
          chk(rsp_valid && rsp_hit == v[1], "R2 R3 table hit flag", 32'(rsp_hit), 32'(v[1]));
          chk(rsp_ppn == (v[1] ? v[13:2] : '0), "R3 table ppn", 32'(rsp_ppn),
              32'(v[1] ? v[13:2] : 12'h0));
        end
        OP_FILL:   fill(v[32:14], v[13:2], 1'b0, 1'b0);
        OP_FLUSH:  do_flush();
        default:   fill(v[32:14], v[13:2], 1'b0, 1'b1);
      endcase
      chk(wb_valid == 1'b0, "R8 R9 R10 no write-back in table", 32'(wb_valid), 0);
    end

    full_case(1'b0, 19'h00300, 12'hABC);
    full_case(1'b1, 19'h00400, 12'hDEF);

    // R8: flush with modified entries raises no strobe, then all miss
    do_flush();
    chk(wb_valid == 1'b0, "R8 flush raises no write-back", 32'(wb_valid), 0);
    lookup(19'h00400, 1'b0);
    chk(!rsp_hit, "R8 lookup after flush misses", 32'(rsp_hit), 0);

    finish_run();
  end

endmodule